// File: doc/BRIEF.md
# Pull-Paced Byte Link Endpoint

This block sits between two byte-wide UART ports, each modelled as a valid/ready byte channel, and runs a transfer protocol in which the receiving side sets the pace. It has two engines that can be used apart or wired back to back: a requester, which fetches a stream of bytes from a peer, and a responder, which serves that stream. The transmit line of each endpoint is wired to the receive line of the other. For every byte it wants, the requester first sends one pull byte, and then waits for the reply. The responder holds its next outgoing byte in a one-byte register with a pending flag. It sends that byte only after a pull byte has arrived. As a result the responder can never send more bytes than the requester asked for.

The requester opens two kinds of exchange. Straight after reset it asks for the file list on its own. When the user requests a program operation, it sends a program command followed by the selected entry index. The responder decodes these commands and reports them to its local user with one-cycle pulses. The user then feeds the reply bytes and marks the end of the stream, and the responder closes the stream with a terminator byte. A programmable watchdog in the requester raises a sticky error flag if a pull goes unanswered.

Requester states: `RQ_BOOT` moves to `RQ_SEND_CMD` unconditionally. `RQ_IDLE` moves to `RQ_SEND_CMD` on a program request. `RQ_SEND_CMD` moves to `RQ_SEND_IDX` (program) or `RQ_SEND_PULL` (list) once the byte is accepted. `RQ_SEND_IDX` moves to `RQ_SEND_PULL` once accepted. `RQ_SEND_PULL` moves to `RQ_WAIT_BYTE` once the pull byte is accepted. `RQ_WAIT_BYTE` moves to `RQ_DELIVER` on a data byte, to `RQ_IDLE` on the terminator, or to `RQ_IDLE` on timeout. `RQ_DELIVER` moves to `RQ_SEND_PULL` once the sink accepts the byte. Responder states: `RS_IDLE` moves to `RS_STREAM` on a list command and to `RS_GET_IDX` on a program command. `RS_GET_IDX` moves to `RS_STREAM` on the index byte. `RS_STREAM` moves to `RS_IDLE` once the terminator has been sent.

Top module: `pull_link`

## Requirements
- R1: After reset is released, the first byte the requester transmits is the list command 8'hA1, with no user input.
- R2: A program request accepted while the requester is idle transmits the program command 8'hA2, then the index zero-extended to a byte, then a pull byte.
- R3: For each wanted byte, the requester sends exactly one pull byte (8'h5A). It sends nothing more until the reply has arrived and the sink has accepted it, and it holds sink data stable while the sink is not ready.
- R4: The responder transmits a byte only when a request byte has been received since its previous transmission, and it keeps the byte stable until accepted.
- R5: The responder's outbound register is one byte deep. `rs_src_ready` is low while a byte is pending. A request that arrives before any data is remembered and releases the next loaded byte.
- R6: While streaming, the responder treats every received byte as exactly one request, whatever its value, including command codes.
- R7: In `RS_IDLE`, 8'hA1 yields a one-cycle `rs_cmd_list` pulse. 8'hA2 followed by an index byte yields a one-cycle `rs_cmd_prog` pulse with the low index bits on `rs_cmd_index`. Any other byte is dropped without effect.
- R8: A source beat with `rs_src_end` set queues the terminator 8'h04. After sending it the responder returns to `RS_IDLE`. The requester does not deliver the terminator: it pulses `rq_done` and goes idle.
- R9: With `rq_timeout_limit` L > 0, a reply must arrive within L cycles after the pull byte is accepted. Otherwise `rq_timeout_err` sets on the L-th clock edge and the requester goes idle. A limit of 0 disables the watchdog.
- R10: `rq_timeout_err` is sticky and is cleared when the next program request is accepted.
- R11: In loopback, the bytes delivered at the requester sink equal, in order, the data bytes offered at the responder source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_prog_req | input | 1 | Start a program exchange (honoured when idle) |
| rq_prog_index | input | IDX_W | Selected entry index |
| rq_timeout_limit | input | TMO_W | Reply window in cycles, 0 disables |
| rq_busy | output | 1 | Requester not idle |
| rq_done | output | 1 | One-cycle pulse when the terminator arrives |
| rq_timeout_err | output | 1 | Sticky reply timeout flag |
| rq_tx_valid | output | 1 | Requester byte to UART transmitter valid |
| rq_tx_data | output | 8 | Requester byte to transmit |
| rq_tx_ready | input | 1 | Transmitter accepts the byte |
| rq_rx_valid | input | 1 | Byte received by requester UART valid |
| rq_rx_data | input | 8 | Received byte |
| rq_rx_ready | output | 1 | Requester consumes the received byte |
| rq_sink_valid | output | 1 | Delivered stream byte valid |
| rq_sink_data | output | 8 | Delivered stream byte |
| rq_sink_ready | input | 1 | Local consumer accepts the byte |
| rs_rx_valid | input | 1 | Byte received by responder UART valid |
| rs_rx_data | input | 8 | Received byte |
| rs_rx_ready | output | 1 | Responder consumes the received byte |
| rs_tx_valid | output | 1 | Responder byte to transmit valid |
| rs_tx_data | output | 8 | Responder byte to transmit |
| rs_tx_ready | input | 1 | Transmitter accepts the byte |
| rs_src_valid | input | 1 | Local producer offers a stream beat |
| rs_src_data | input | 8 | Stream data byte |
| rs_src_end | input | 1 | Beat marks end of stream (data ignored) |
| rs_src_ready | output | 1 | Responder accepts the beat |
| rs_cmd_list | output | 1 | One-cycle pulse: list command decoded |
| rs_cmd_prog | output | 1 | One-cycle pulse: program command and index decoded |
| rs_cmd_index | output | IDX_W | Index from the last program command |

## Verification
The stability assertions on both transmit channels and on the sink assume that the UART models and the local consumer obey valid/ready. That means a ready input may be held low indefinitely but never withdraws a byte that has already been handed over. The bench's drivers likewise hold every received byte and source beat until the block raises its ready. The single-credit and no-overwrite checks in the responder assume that the peer sends at most one request per byte it wants. In loopback that comes from the requester itself. In the directed responder tests the bench sends one request only after each reply has been taken. All inputs change on the falling clock edge, so no handshake is ever offered or withdrawn at the sampling edge.

// File: rtl/pull_link_pkg.sv
package pull_link_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        RQ_BOOT,
        RQ_IDLE,
        RQ_SEND_CMD,
        RQ_SEND_IDX,
        RQ_SEND_PULL,
        RQ_WAIT_BYTE,
        RQ_DELIVER
    } rq_state_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_GET_IDX,
        RS_STREAM
    } rs_state_t;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_LIST,
        CK_PROG
    } cmd_kind_t;

endpackage

// File: rtl/pl_cmd_decode.sv
module pl_cmd_decode
    import pull_link_pkg::*;
#(
    parameter byte_t CODE_LIST = 8'hA1,
    parameter byte_t CODE_PROG = 8'hA2
) (
    input  byte_t     code,
    output cmd_kind_t kind
);

    always_comb begin
        if (code == CODE_LIST) begin
            kind = CK_LIST;
        end else if (code == CODE_PROG) begin
            kind = CK_PROG;
        end else begin
            kind = CK_NONE;
        end
    end

endmodule

// File: rtl/pl_out_hold.sv
module pl_out_hold
    import pull_link_pkg::*;
#(
    parameter byte_t TERM_BYTE = 8'h04
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_data,
    input  logic  load_end,
    input  logic  send,
    output logic  pending,
    output byte_t data,
    output logic  is_term
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            data    <= '0;
            is_term <= 1'b0;
        end else if (load) begin
            pending <= 1'b1;
            data    <= load_end ? TERM_BYTE : load_data;
            is_term <= load_end;
        end else if (send) begin
            pending <= 1'b0;
            is_term <= 1'b0;
        end
    end

    // R5: one byte deep, never overwritten while pending
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !pending)
        else $error("hold register overwritten while pending");

    // R4: a send always drains a byte that was held
    assert_send_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> pending)
        else $error("send with empty hold register");

endmodule

// File: rtl/pl_requester.sv
module pl_requester
    import pull_link_pkg::*;
#(
    parameter int    IDX_W     = 3,
    parameter int    TMO_W     = 16,
    parameter byte_t PULL_BYTE = 8'h5A,
    parameter byte_t TERM_BYTE = 8'h04,
    parameter byte_t CODE_LIST = 8'hA1,
    parameter byte_t CODE_PROG = 8'hA2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_req,
    input  logic [IDX_W-1:0] prog_index,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             busy,
    output logic             done,
    output logic             tmo_err,
    output logic             tx_valid,
    output byte_t            tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  byte_t            rx_data,
    output logic             rx_ready,
    output logic             sink_valid,
    output byte_t            sink_data,
    input  logic             sink_ready
);

    localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);

    rq_state_t        state, state_n;
    logic             kind_prog;
    logic [IDX_W-1:0] idx_q;
    byte_t            rx_q;
    logic [TMO_W-1:0] tmo_cnt;
    logic             tmo_hit;
    logic             got_term;

    assign tmo_hit  = (tmo_limit != '0) && (tmo_cnt == tmo_limit - TMO_ONE);
    assign got_term = (rx_data == TERM_BYTE);

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            RQ_BOOT:      state_n = RQ_SEND_CMD;
            RQ_IDLE:      if (prog_req) state_n = RQ_SEND_CMD;
            RQ_SEND_CMD:  if (tx_ready) state_n = kind_prog ? RQ_SEND_IDX : RQ_SEND_PULL;
            RQ_SEND_IDX:  if (tx_ready) state_n = RQ_SEND_PULL;
            RQ_SEND_PULL: if (tx_ready) state_n = RQ_WAIT_BYTE;
            RQ_WAIT_BYTE: begin
                if (rx_valid) begin
                    state_n = got_term ? RQ_IDLE : RQ_DELIVER;
                end else if (tmo_hit) begin
                    state_n = RQ_IDLE;
                end
            end
            RQ_DELIVER:   if (sink_ready) state_n = RQ_SEND_PULL;
            default:      state_n = RQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RQ_BOOT;
        end else begin
            state <= state_n;
        end
    end

    // outputs
    always_comb begin
        tx_valid   = 1'b0;
        tx_data    = PULL_BYTE;
        rx_ready   = 1'b0;
        sink_valid = 1'b0;
        unique case (state)
            RQ_BOOT: ;
            RQ_IDLE:      rx_ready = 1'b1;
            RQ_SEND_CMD: begin
                tx_valid = 1'b1;
                tx_data  = kind_prog ? CODE_PROG : CODE_LIST;
            end
            RQ_SEND_IDX: begin
                tx_valid = 1'b1;
                tx_data  = 8'(idx_q);
            end
            RQ_SEND_PULL: tx_valid = 1'b1;
            RQ_WAIT_BYTE: rx_ready = 1'b1;
            RQ_DELIVER:   sink_valid = 1'b1;
            default: ;
        endcase
    end

    assign sink_data = rx_q;
    assign busy      = (state != RQ_IDLE);

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_prog <= 1'b0;
            idx_q     <= '0;
            rx_q      <= '0;
            tmo_cnt   <= '0;
            tmo_err   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= (state == RQ_WAIT_BYTE) && rx_valid && got_term;
            if (state == RQ_BOOT) begin
                kind_prog <= 1'b0;
            end
            if ((state == RQ_IDLE) && prog_req) begin
                kind_prog <= 1'b1;
                idx_q     <= prog_index;
                tmo_err   <= 1'b0;
            end
            if ((state == RQ_SEND_PULL) && tx_ready) begin
                tmo_cnt <= '0;
            end
            if (state == RQ_WAIT_BYTE) begin
                tmo_cnt <= tmo_cnt + TMO_ONE;
                if (rx_valid && !got_term) begin
                    rx_q <= rx_data;
                end
                if (!rx_valid && tmo_hit) begin
                    tmo_err <= 1'b1;
                end
            end
        end
    end

    // R3: a transmit byte is held until the UART takes it
    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
        else $error("requester tx byte withdrawn");

    // R3: after a pull byte leaves, nothing else is sent before the reply
    assert_one_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RQ_SEND_PULL && tx_ready) |=> !tx_valid)
        else $error("second byte sent before reply");

    // R3: delivered byte is held until the sink takes it
    assert_sink_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_valid && !sink_ready) |=> (sink_valid && $stable(sink_data)))
        else $error("sink byte withdrawn");

    // R9: a timeout always leaves the requester idle
    assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> !busy)
        else $error("timeout flag set while busy");

endmodule

// File: rtl/pl_responder.sv
module pl_responder
    import pull_link_pkg::*;
#(
    parameter int    IDX_W     = 3,
    parameter byte_t TERM_BYTE = 8'h04,
    parameter byte_t CODE_LIST = 8'hA1,
    parameter byte_t CODE_PROG = 8'hA2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  byte_t            rx_data,
    output logic             rx_ready,
    output logic             tx_valid,
    output byte_t            tx_data,
    input  logic             tx_ready,
    input  logic             src_valid,
    input  byte_t            src_data,
    input  logic             src_end,
    output logic             src_ready,
    output logic             cmd_list,
    output logic             cmd_prog,
    output logic [IDX_W-1:0] cmd_index
);

    rs_state_t state, state_n;
    cmd_kind_t rx_kind;
    logic      req_seen;
    logic      rx_fire, tx_fire, load;
    logic      hold_pending, hold_term;
    byte_t     hold_data;

    pl_cmd_decode #(
        .CODE_LIST (CODE_LIST),
        .CODE_PROG (CODE_PROG)
    ) u_dec (
        .code (rx_data),
        .kind (rx_kind)
    );

    pl_out_hold #(
        .TERM_BYTE (TERM_BYTE)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (src_data),
        .load_end  (src_end),
        .send      (tx_fire),
        .pending   (hold_pending),
        .data      (hold_data),
        .is_term   (hold_term)
    );

    assign rx_fire = rx_valid && rx_ready;
    assign tx_fire = tx_valid && tx_ready;
    assign load    = src_valid && src_ready;

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            RS_IDLE: begin
                if (rx_fire && rx_kind == CK_LIST) begin
                    state_n = RS_STREAM;
                end else if (rx_fire && rx_kind == CK_PROG) begin
                    state_n = RS_GET_IDX;
                end
            end
            RS_GET_IDX: if (rx_fire) state_n = RS_STREAM;
            RS_STREAM:  if (tx_fire && hold_term) state_n = RS_IDLE;
            default:    state_n = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // outputs
    always_comb begin
        rx_ready  = 1'b0;
        src_ready = 1'b0;
        tx_valid  = 1'b0;
        unique case (state)
            RS_IDLE:    rx_ready = 1'b1;
            RS_GET_IDX: rx_ready = 1'b1;
            RS_STREAM: begin
                rx_ready  = !req_seen;
                src_ready = !hold_pending;
                tx_valid  = hold_pending && req_seen;
            end
            default: ;
        endcase
    end

    assign tx_data = hold_data;

    // request credit and command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen  <= 1'b0;
            cmd_list  <= 1'b0;
            cmd_prog  <= 1'b0;
            cmd_index <= '0;
        end else begin
            if (tx_fire) begin
                req_seen <= 1'b0;
            end else if ((state == RS_STREAM) && rx_fire) begin
                req_seen <= 1'b1;
            end
            cmd_list <= (state == RS_IDLE) && rx_fire && (rx_kind == CK_LIST);
            cmd_prog <= (state == RS_GET_IDX) && rx_fire;
            if ((state == RS_GET_IDX) && rx_fire) begin
                cmd_index <= rx_data[IDX_W-1:0];
            end
        end
    end

    // R4: each transmission consumes its request; no back-to-back sends
    assert_single_send_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |=> !tx_valid)
        else $error("responder sent without a fresh request");

    // R4: an offered byte is held until taken
    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
        else $error("responder tx byte withdrawn");

    // R7: the two command pulses never coincide
    assert_cmd_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_list && cmd_prog))
        else $error("both command pulses high");

    // R8: after the terminator leaves, the responder is back in idle
    assert_term_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fire && hold_term) |=> (state == RS_IDLE))
        else $error("stream not closed after terminator");

endmodule

// File: rtl/pull_link.sv
module pull_link
    import pull_link_pkg::*;
#(
    parameter int    IDX_W     = 3,
    parameter int    TMO_W     = 16,
    parameter byte_t PULL_BYTE = 8'h5A,
    parameter byte_t TERM_BYTE = 8'h04,
    parameter byte_t CODE_LIST = 8'hA1,
    parameter byte_t CODE_PROG = 8'hA2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rq_prog_req,
    input  logic [IDX_W-1:0] rq_prog_index,
    input  logic [TMO_W-1:0] rq_timeout_limit,
    output logic             rq_busy,
    output logic             rq_done,
    output logic             rq_timeout_err,
    output logic             rq_tx_valid,
    output logic [7:0]       rq_tx_data,
    input  logic             rq_tx_ready,
    input  logic             rq_rx_valid,
    input  logic [7:0]       rq_rx_data,
    output logic             rq_rx_ready,
    output logic             rq_sink_valid,
    output logic [7:0]       rq_sink_data,
    input  logic             rq_sink_ready,
    input  logic             rs_rx_valid,
    input  logic [7:0]       rs_rx_data,
    output logic             rs_rx_ready,
    output logic             rs_tx_valid,
    output logic [7:0]       rs_tx_data,
    input  logic             rs_tx_ready,
    input  logic             rs_src_valid,
    input  logic [7:0]       rs_src_data,
    input  logic             rs_src_end,
    output logic             rs_src_ready,
    output logic             rs_cmd_list,
    output logic             rs_cmd_prog,
    output logic [IDX_W-1:0] rs_cmd_index
);

    pl_requester #(
        .IDX_W     (IDX_W),
        .TMO_W     (TMO_W),
        .PULL_BYTE (PULL_BYTE),
        .TERM_BYTE (TERM_BYTE),
        .CODE_LIST (CODE_LIST),
        .CODE_PROG (CODE_PROG)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_req   (rq_prog_req),
        .prog_index (rq_prog_index),
        .tmo_limit  (rq_timeout_limit),
        .busy       (rq_busy),
        .done       (rq_done),
        .tmo_err    (rq_timeout_err),
        .tx_valid   (rq_tx_valid),
        .tx_data    (rq_tx_data),
        .tx_ready   (rq_tx_ready),
        .rx_valid   (rq_rx_valid),
        .rx_data    (rq_rx_data),
        .rx_ready   (rq_rx_ready),
        .sink_valid (rq_sink_valid),
        .sink_data  (rq_sink_data),
        .sink_ready (rq_sink_ready)
    );

    pl_responder #(
        .IDX_W     (IDX_W),
        .TERM_BYTE (TERM_BYTE),
        .CODE_LIST (CODE_LIST),
        .CODE_PROG (CODE_PROG)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rs_rx_valid),
        .rx_data   (rs_rx_data),
        .rx_ready  (rs_rx_ready),
        .tx_valid  (rs_tx_valid),
        .tx_data   (rs_tx_data),
        .tx_ready  (rs_tx_ready),
        .src_valid (rs_src_valid),
        .src_data  (rs_src_data),
        .src_end   (rs_src_end),
        .src_ready (rs_src_ready),
        .cmd_list  (rs_cmd_list),
        .cmd_prog  (rs_cmd_prog),
        .cmd_index (rs_cmd_index)
    );

endmodule

// File: tb/sim_pull_link.sv
module sim_pull_link;

    localparam logic [7:0] PULL  = 8'h5A;
    localparam logic [7:0] TERM  = 8'h04;
    localparam logic [7:0] CLIST = 8'hA1;
    localparam logic [7:0] CPROG = 8'hA2;

    logic        clk, rst_n, loop_en;
    logic        rq_prog_req;
    logic [2:0]  rq_prog_index;
    logic [15:0] rq_timeout_limit;
    logic        rq_busy, rq_done, rq_timeout_err;
    logic        rq_tx_valid, rq_tx_ready, rq_rx_valid, rq_rx_ready;
    logic [7:0]  rq_tx_data, rq_rx_data, rq_sink_data;
    logic        rq_sink_valid, rq_sink_ready;
    logic        rs_rx_valid, rs_rx_ready, rs_tx_valid, rs_tx_ready;
    logic [7:0]  rs_rx_data, rs_tx_data, rs_src_data;
    logic        rs_src_valid, rs_src_end, rs_src_ready;
    logic        rs_cmd_list, rs_cmd_prog;
    logic [2:0]  rs_cmd_index;

    logic        b_rq_tx_ready, b_rq_rx_valid, b_rs_rx_valid, b_rs_tx_ready;
    logic [7:0]  b_rq_rx_data, b_rs_rx_data;

    always_comb begin
        rq_rx_valid = loop_en ? rs_tx_valid : b_rq_rx_valid;
        rq_rx_data  = loop_en ? rs_tx_data  : b_rq_rx_data;
        rs_tx_ready = loop_en ? rq_rx_ready : b_rs_tx_ready;
        rs_rx_valid = loop_en ? rq_tx_valid : b_rs_rx_valid;
        rs_rx_data  = loop_en ? rq_tx_data  : b_rs_rx_data;
        rq_tx_ready = loop_en ? rs_rx_ready : b_rq_tx_ready;
    end

    pull_link u0 (
        .clk(clk), .rst_n(rst_n),
        .rq_prog_req(rq_prog_req), .rq_prog_index(rq_prog_index),
        .rq_timeout_limit(rq_timeout_limit),
        .rq_busy(rq_busy), .rq_done(rq_done), .rq_timeout_err(rq_timeout_err),
        .rq_tx_valid(rq_tx_valid), .rq_tx_data(rq_tx_data), .rq_tx_ready(rq_tx_ready),
        .rq_rx_valid(rq_rx_valid), .rq_rx_data(rq_rx_data), .rq_rx_ready(rq_rx_ready),
        .rq_sink_valid(rq_sink_valid), .rq_sink_data(rq_sink_data), .rq_sink_ready(rq_sink_ready),
        .rs_rx_valid(rs_rx_valid), .rs_rx_data(rs_rx_data), .rs_rx_ready(rs_rx_ready),
        .rs_tx_valid(rs_tx_valid), .rs_tx_data(rs_tx_data), .rs_tx_ready(rs_tx_ready),
        .rs_src_valid(rs_src_valid), .rs_src_data(rs_src_data), .rs_src_end(rs_src_end),
        .rs_src_ready(rs_src_ready),
        .rs_cmd_list(rs_cmd_list), .rs_cmd_prog(rs_cmd_prog), .rs_cmd_index(rs_cmd_index)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int vec_n = 0;
    int err_n = 0;

    logic [7:0] rqtx_log [0:63];
    logic [7:0] rstx_log [0:63];
    logic [7:0] sink_log [0:63];
    int rqtx_n, rstx_n, sink_n, list_n, prog_n, done_n;

    // passive monitor, sampled 1 ns after the falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (rq_tx_valid && rq_tx_ready) begin
                if (rqtx_n < 64) rqtx_log[rqtx_n] = rq_tx_data;
                rqtx_n++;
            end
            if (rs_tx_valid && rs_tx_ready) begin
                if (rstx_n < 64) rstx_log[rstx_n] = rs_tx_data;
                rstx_n++;
            end
            if (rq_sink_valid && rq_sink_ready) begin
                if (sink_n < 64) sink_log[sink_n] = rq_sink_data;
                sink_n++;
            end
            if (rs_cmd_list) list_n++;
            if (rs_cmd_prog) prog_n++;
            if (rq_done) done_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_n++;
        if (act !== exp) begin
            err_n++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rqtx_n = 0; rstx_n = 0; sink_n = 0;
        list_n = 0; prog_n = 0; done_n = 0;
    endtask

    task automatic src_push(input logic [7:0] d, input logic last);
        rs_src_valid = 1'b1;
        rs_src_data  = d;
        rs_src_end   = last;
        while (!rs_src_ready) @(negedge clk);
        @(negedge clk);
        rs_src_valid = 1'b0;
        rs_src_end   = 1'b0;
    endtask

    task automatic rs_send(input logic [7:0] d);
        b_rs_rx_valid = 1'b1;
        b_rs_rx_data  = d;
        while (!rs_rx_ready) @(negedge clk);
        @(negedge clk);
        b_rs_rx_valid = 1'b0;
    endtask

    task automatic rs_take();
        b_rs_tx_ready = 1'b1;
        @(negedge clk);
        b_rs_tx_ready = 1'b0;
    endtask

    task automatic prog(input logic [2:0] idx);
        rq_prog_index = idx;
        rq_prog_req   = 1'b1;
        @(negedge clk);
        rq_prog_req   = 1'b0;
    endtask

    task automatic wait_pull();
        while (!(rq_tx_valid && rq_tx_data == PULL)) @(negedge clk);
    endtask

    // Scenario: list fetch issued by the requester itself after reset
    task automatic t_boot_list();
        while (list_n == 0) @(negedge clk);
        src_push(8'h31, 1'b0);
        src_push(8'h32, 1'b0);
        src_push(8'h33, 1'b0);
        src_push(8'h00, 1'b1);
        while (done_n == 0) @(negedge clk);
        @(negedge clk);
        check("R1 first requester byte", rqtx_log[0], CLIST);
        check("R7 list pulse count", list_n, 1);
        check("R7 no prog pulse", prog_n, 0);
        check("R11 sink count", sink_n, 3);
        check("R11 sink byte0", sink_log[0], 8'h31);
        check("R11 sink byte1", sink_log[1], 8'h32);
        check("R11 sink byte2", sink_log[2], 8'h33);
        check("R3 requester byte count", rqtx_n, 5);
        for (int i = 1; i < 5; i++) check("R3 pull byte value", rqtx_log[i], PULL);
        check("R8 terminator sent", rstx_log[3], TERM);
        check("R8 done pulse", done_n, 1);
        check("R8 requester idle", rq_busy, 1'b0);
    endtask

    // Scenario: program exchange with a stalled consumer
    task automatic t_prog_backpressure();
        int n0;
        clear_logs();
        rq_sink_ready = 1'b0;
        prog(3'd5);
        while (prog_n == 0) @(negedge clk);
        check("R7 prog index", rs_cmd_index, 3'd5);
        src_push(8'hC1, 1'b0);
        while (!rq_sink_valid) @(negedge clk);
        check("R11 first delivered", rq_sink_data, 8'hC1);
        n0 = rqtx_n;
        src_push(8'hC2, 1'b0);
        rs_src_valid = 1'b1;
        rs_src_end   = 1'b1;
        repeat (6) @(negedge clk);
        check("R5 source blocked while pending", rs_src_ready, 1'b0);
        check("R4 no unrequested send", rs_tx_valid, 1'b0);
        check("R3 no pull during stall", rqtx_n, n0);
        check("R3 sink held valid", rq_sink_valid, 1'b1);
        check("R3 sink held data", rq_sink_data, 8'hC1);
        rq_sink_ready = 1'b1;
        while (!rs_src_ready) @(negedge clk);
        @(negedge clk);
        rs_src_valid = 1'b0;
        rs_src_end   = 1'b0;
        while (done_n == 0) @(negedge clk);
        @(negedge clk);
        check("R2 command byte", rqtx_log[0], CPROG);
        check("R2 index byte", rqtx_log[1], 8'h05);
        check("R2 first pull", rqtx_log[2], PULL);
        check("R3 pulls before stall", n0, 3);
        check("R11 sink count", sink_n, 2);
        check("R11 second delivered", sink_log[1], 8'hC2);
        check("R8 last responder byte", rstx_log[2], TERM);
    endtask

    // Scenario: responder driven directly
    task automatic t_responder_direct();
        clear_logs();
        loop_en = 1'b0;
        @(negedge clk);
        rs_send(8'h33);
        repeat (3) @(negedge clk);
        check("R7 stray byte no list pulse", list_n, 0);
        check("R7 stray byte no prog pulse", prog_n, 0);
        check("R4 idle no tx", rs_tx_valid, 1'b0);
        rs_send(CLIST);
        @(negedge clk);
        check("R7 list decoded", list_n, 1);
        rs_send(CPROG);
        repeat (2) @(negedge clk);
        check("R6 command code in stream not decoded", prog_n, 0);
        check("R5 nothing pending yet", rs_tx_valid, 1'b0);
        src_push(8'h77, 1'b0);
        check("R5 early request releases byte", rs_tx_valid, 1'b1);
        check("R5 released data", rs_tx_data, 8'h77);
        rs_take();
        src_push(8'h78, 1'b0);
        repeat (3) @(negedge clk);
        check("R4 held byte waits for request", rs_tx_valid, 1'b0);
        rs_send(PULL);
        check("R6 any byte is a request", rs_tx_valid, 1'b1);
        check("R6 data", rs_tx_data, 8'h78);
        rs_take();
        src_push(8'h00, 1'b1);
        rs_send(8'hEE);
        check("R8 terminator value", rs_tx_data, TERM);
        rs_take();
        @(negedge clk);
        rs_send(CLIST);
        @(negedge clk);
        check("R8 back in idle after terminator", list_n, 2);
    endtask

    // Scenario: requester watchdog driven directly
    task automatic t_requester_timeout();
        clear_logs();
        loop_en = 1'b0;
        b_rq_tx_ready = 1'b1;
        rq_timeout_limit = 16'd8;
        @(negedge clk);
        prog(3'd2);
        wait_pull();
        repeat (8) @(negedge clk);
        check("R9 no error inside window", rq_timeout_err, 1'b0);
        check("R9 still waiting", rq_busy, 1'b1);
        @(negedge clk);
        check("R9 error on last edge", rq_timeout_err, 1'b1);
        check("R9 idle after timeout", rq_busy, 1'b0);
        check("R2 index byte", rqtx_log[1], 8'h02);
        prog(3'd2);
        check("R10 error cleared", rq_timeout_err, 1'b0);
        wait_pull();
        repeat (8) @(negedge clk);
        b_rq_rx_valid = 1'b1;
        b_rq_rx_data  = TERM;
        @(negedge clk);
        b_rq_rx_valid = 1'b0;
        check("R9 reply in last cycle accepted", rq_timeout_err, 1'b0);
        check("R8 done on terminator", rq_done, 1'b1);
        check("R8 idle after terminator", rq_busy, 1'b0);
        rq_timeout_limit = 16'd0;
        prog(3'd1);
        wait_pull();
        repeat (60) @(negedge clk);
        check("R9 limit zero disables", rq_timeout_err, 1'b0);
        check("R9 limit zero keeps waiting", rq_busy, 1'b1);
        b_rq_rx_valid = 1'b1;
        b_rq_rx_data  = TERM;
        @(negedge clk);
        b_rq_rx_valid = 1'b0;
        @(negedge clk);
        check("R8 idle after late terminator", rq_busy, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        err_n++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
        $finish;
    end

    initial begin
        rst_n = 1'b0; loop_en = 1'b1;
        rq_prog_req = 1'b0; rq_prog_index = '0; rq_timeout_limit = 16'd50;
        rq_sink_ready = 1'b1;
        rs_src_valid = 1'b0; rs_src_data = '0; rs_src_end = 1'b0;
        b_rq_tx_ready = 1'b0; b_rq_rx_valid = 1'b0; b_rq_rx_data = '0;
        b_rs_rx_valid = 1'b0; b_rs_rx_data = '0; b_rs_tx_ready = 1'b0;
        clear_logs();
        repeat (3) @(negedge clk);
        check("R4 reset no responder tx", rs_tx_valid, 1'b0);
        check("R3 reset no sink byte", rq_sink_valid, 1'b0);
        check("R9 reset no error", rq_timeout_err, 1'b0);
        check("R8 reset no done", rq_done, 1'b0);
        rst_n = 1'b1;
        t_boot_list();
        t_prog_backpressure();
        t_responder_direct();
        t_requester_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
        $finish;
    end

endmodule